// File: doc/BRIEF.md
# GPIO Input Event Sampler

This block watches a vector of input channels, eight by default. Each channel is first captured into a register. It then passes through its own short shift register, which can add 0 to 3 more clock cycles of delay. The delayed values form the sampled input word. Software can read that word at any time.

Every channel also has its own event detector. The detector can match a rising edge, a falling edge, either edge, a low level or a high level. A match sets a sticky per-channel status bit. The bit stays set until software writes a one to it in a separate clear register. An enable mask selects which status bits drive the single interrupt output. Status bits still latch on channels that are not enabled, so software can poll them.

All configuration goes through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational on the address. The interrupt controller and any pad synchronisers ahead of the sampler sit outside this block.

Top module: `gpio_event_sampler`

## Requirements
- R1: While reset is held and straight after it, the delay, kind, enable and status registers all read 0, the sampled input word reads 0 and `irq` is low.
- R2: Bit c of the sampled input word (read address 5) equals `rawIn[c]` delayed by 1+d clock cycles. Here d is the 2-bit delay field at bits 2c+1:2c of the delay register (address 0, read/write).
- R3: The kind field for channel c sits at bits 3c+2:3c of the kind register (address 1, read/write). Kind 1 matches a rising edge, kind 2 a falling edge and kind 3 either edge. An edge is a difference between the current sampled value and the sampled value one cycle earlier. A match sets status bit c at the next clock edge.
- R4: Kind 4 (low) and kind 5 (high) match on every cycle in which the sampled value is at that level. A clear issued while the level persists therefore leaves the status bit set.
- R5: Kind codes 0, 6 and 7 never set a status bit.
- R6: The status register (address 3, read-only) holds each latched event bit, whether or not the channel is enabled. A bit stays set until it is cleared.
- R7: A write to address 4 clears the status bits at the positions where the written mask is 1. Bits written as 0 are left unchanged. Address 4 reads as 0.
- R8: When a clear and a new event hit the same channel in the same cycle, the event wins and the status bit stays set.
- R9: `irq` is high exactly when some channel has both its status bit and its enable bit set. It follows the registers with no added delay.
- R10: The enable register (address 2) can be written whole. A write to address 6 sets the enable bits where the data is 1, and a write to address 7 clears the enable bits where the data is 1.
- R11: Writes to the read-only addresses 3 and 5 change nothing. Addresses 4, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for `busAddr` |
| rawIn | input | NUM_CH | Raw input channels |
| irq | output | 1 | Interrupt: OR of status AND enable |

## Verification
The assertions check four things on every cycle:
- a detected event is always reflected in the status word one edge later, even when a clear arrives in the same cycle;
- no status bit rises without a detected event;
- a clear removes every bit it covers that had no competing event;
- status bits hold when no clear is written, and `irq` stays low when nothing is enabled or nothing is latched.

The delay taps, the decoding of each kind code and the set/clear behaviour of the enable register need the bench scenarios. The bench compares every cycle against its reference model of the sampled word and the status word.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DELAY  = 3'd0;
  localparam logic [ADDR_W-1:0] A_KIND   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_INPUT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_EN_SET = 3'd6;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 3'd7;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    EV_NONE = 3'd0,
    EV_RISE = 3'd1,
    EV_FALL = 3'd2,
    EV_ANY  = 3'd3,
    EV_LOW  = 3'd4,
    EV_HIGH = 3'd5
  } evKind_e;

  typedef struct packed {
    logic wrDelay;
    logic wrKind;
    logic wrEnable;
    logic setEnable;
    logic clrEnable;
    logic clrStatus;
  } ctlStrobe_t;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic              cur,
  input  logic              prev,
  input  logic [KIND_W-1:0] kind,
  output logic              hit
);

  always_comb begin
    case (kind)
      EV_RISE: hit = cur & ~prev;
      EV_FALL: hit = ~cur & prev;
      EV_ANY:  hit = cur ^ prev;
      EV_LOW:  hit = ~cur;
      EV_HIGH: hit = cur;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int DLY_BITS = 16
) (
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [DLY_BITS-1:0]      rdDelay,
  input  logic [NUM_CH*KIND_W-1:0] rdKind,
  input  logic [NUM_CH-1:0]        rdEnable,
  input  logic [NUM_CH-1:0]        rdStatus,
  input  logic [NUM_CH-1:0]        rdInput,
  output ctlStrobe_t               strobe,
  output logic [DATA_W-1:0]        busRdData
);

  localparam int KIND_BITS = NUM_CH * KIND_W;

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      case (busAddr)
        A_DELAY:  strobe.wrDelay   = 1'b1;
        A_KIND:   strobe.wrKind    = 1'b1;
        A_ENABLE: strobe.wrEnable  = 1'b1;
        A_CLEAR:  strobe.clrStatus = 1'b1;
        A_EN_SET: strobe.setEnable = 1'b1;
        A_EN_CLR: strobe.clrEnable = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_DELAY:  busRdData[DLY_BITS-1:0]  = rdDelay;
      A_KIND:   busRdData[KIND_BITS-1:0] = rdKind;
      A_ENABLE: busRdData[NUM_CH-1:0]    = rdEnable;
      A_STATUS: busRdData[NUM_CH-1:0]    = rdStatus;
      A_INPUT:  busRdData[NUM_CH-1:0]    = rdInput;
      default:  busRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int MAX_DLY = 3,
  parameter int DLY_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               strobe,
  input  logic [NUM_CH*KIND_W-1:0] wrData,
  input  logic [NUM_CH-1:0]        rawIn,
  output logic [NUM_CH*DLY_W-1:0]  delayQ,
  output logic [NUM_CH*KIND_W-1:0] kindQ,
  output logic [NUM_CH-1:0]        enableQ,
  output logic [NUM_CH-1:0]        statusQ,
  output logic [NUM_CH-1:0]        sampled,
  output logic [NUM_CH-1:0]        evtVec,
  output logic                     irq
);

  localparam int DEPTH     = MAX_DLY + 1;
  localparam int DLY_BITS  = NUM_CH * DLY_W;
  localparam int KIND_BITS = NUM_CH * KIND_W;

  logic [NUM_CH-1:0] prevQ;
  logic [NUM_CH-1:0] maskData;
  logic [NUM_CH-1:0] clrMask;

  assign maskData = wrData[NUM_CH-1:0];
  assign clrMask  = strobe.clrStatus ? maskData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayQ <= '0;
      kindQ  <= '0;
    end else begin
      if (strobe.wrDelay) delayQ <= wrData[DLY_BITS-1:0];
      if (strobe.wrKind)  kindQ  <= wrData[KIND_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobe.wrEnable) begin
      enableQ <= maskData;
    end else if (strobe.setEnable) begin
      enableQ <= enableQ | maskData;
    end else if (strobe.clrEnable) begin
      enableQ <= enableQ & ~maskData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      prevQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | evtVec;
      prevQ   <= sampled;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [DEPTH-1:0] tap;
    logic [DLY_W-1:0] sel;

    assign sel = delayQ[g*DLY_W +: DLY_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tap <= '0;
      else       tap <= {tap[DEPTH-2:0], rawIn[g]};
    end

    always_comb begin
      if (int'(sel) > MAX_DLY) sampled[g] = tap[MAX_DLY];
      else                     sampled[g] = tap[sel];
    end

    gpio_evt_detect detect_i (
      .cur  (sampled[g]),
      .prev (prevQ[g]),
      .kind (kindQ[g*KIND_W +: KIND_W]),
      .hit  (evtVec[g])
    );
  end

  assign irq = |(statusQ & enableQ);

endmodule

// File: rtl/gpio_event_sampler.sv
module gpio_event_sampler
  import gpio_evt_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 32,
  parameter int MAX_DLY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_CH-1:0] rawIn,
  output logic              irq
);

  localparam int DLY_W     = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);
  localparam int DLY_BITS  = NUM_CH * DLY_W;
  localparam int KIND_BITS = NUM_CH * KIND_W;

  ctlStrobe_t              strobe;
  logic [DLY_BITS-1:0]     delayQ;
  logic [KIND_BITS-1:0]    kindQ;
  logic [NUM_CH-1:0]       enableQ;
  logic [NUM_CH-1:0]       statusQ;
  logic [NUM_CH-1:0]       sampled;
  logic [NUM_CH-1:0]       evtVec;
  logic                    clrValid;

  assign clrValid = strobe.clrStatus;

  if (DATA_W > KIND_BITS) begin : gHi
    logic unusedWrHi;
    assign unusedWrHi = ^busWrData[DATA_W-1:KIND_BITS];
  end

  gpio_evt_ctrl #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .DLY_BITS (DLY_BITS)
  ) ctrl_i (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .rdDelay   (delayQ),
    .rdKind    (kindQ),
    .rdEnable  (enableQ),
    .rdStatus  (statusQ),
    .rdInput   (sampled),
    .strobe    (strobe),
    .busRdData (busRdData)
  );

  gpio_evt_datapath #(
    .NUM_CH  (NUM_CH),
    .MAX_DLY (MAX_DLY),
    .DLY_W   (DLY_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData[KIND_BITS-1:0]),
    .rawIn   (rawIn),
    .delayQ  (delayQ),
    .kindQ   (kindQ),
    .enableQ (enableQ),
    .statusQ (statusQ),
    .sampled (sampled),
    .evtVec  (evtVec),
    .irq     (irq)
  );

endmodule

// File: rtl/gpio_event_sampler_chk.sv
module gpio_event_sampler_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic [NUM_CH-1:0] statusQ,
  input logic [NUM_CH-1:0] enableQ,
  input logic [NUM_CH-1:0] evtVec,
  input logic              clrValid,
  input logic [NUM_CH-1:0] clrMask
);

  logic seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> ((statusQ & $past(evtVec)) == $past(evtVec))); // R8

  AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> ((statusQ & ~$past(statusQ) & ~$past(evtVec)) == '0)); // R3

  AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(clrValid)) |-> ((statusQ & $past(clrMask) & ~$past(evtVec)) == '0)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !$past(clrValid)) |-> ((statusQ & $past(statusQ)) == $past(statusQ))); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irq); // R9

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |-> !irq); // R9

endmodule

bind gpio_event_sampler gpio_event_sampler_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .irq      (irq),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .evtVec   (evtVec),
  .clrValid (clrValid),
  .clrMask  (busWrData[NUM_CH-1:0])
);

// File: tb/gpio_event_sampler_tb_top.sv
module gpio_event_sampler_tb_top;

  localparam int NCH = 8;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic [NCH-1:0] rawIn = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_event_sampler #(.NUM_CH(NCH), .DATA_W(DW), .MAX_DLY(3)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .rawIn     (rawIn),
    .irq       (irq)
  );

  // Behavioural reference model
  logic [31:0]    mDelay = '0;
  logic [31:0]    mKind  = '0;
  logic [NCH-1:0] mEn    = '0;
  logic [NCH-1:0] mSt    = '0;
  logic [NCH-1:0] mPrev  = '0;
  logic [NCH-1:0] hist[$];

  function automatic logic [NCH-1:0] mSampled();
    logic [NCH-1:0] s;
    for (int c = 0; c < NCH; c++) begin
      int d;
      d = int'(mDelay[2*c +: 2]);
      s[c] = (hist.size() > d) ? hist[d][c] : 1'b0;
    end
    return s;
  endfunction

  function automatic logic [NCH-1:0] mEvents(logic [NCH-1:0] cur);
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++) begin
      int k;
      k = int'(mKind[3*c +: 3]);
      case (k)
        1: e[c] = cur[c] && !mPrev[c];
        2: e[c] = !cur[c] && mPrev[c];
        3: e[c] = cur[c] != mPrev[c];
        4: e[c] = !cur[c];
        5: e[c] = cur[c];
        default: e[c] = 1'b0;
      endcase
    end
    return e;
  endfunction

  function automatic logic [DW-1:0] mRead(logic [2:0] a);
    case (a)
      3'd0: return mDelay;
      3'd1: return mKind;
      3'd2: return DW'(mEn);
      3'd3: return DW'(mSt);
      3'd5: return DW'(mSampled());
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(logic [2:0] a);
    case (a)
      3'd0, 3'd5: return "R2";
      3'd1: return "R3";
      3'd2: return "R10";
      3'd3: return "R6";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDelay = '0; mKind = '0; mEn = '0; mSt = '0; mPrev = '0;
      hist.delete();
    end else begin
      logic [NCH-1:0] cur;
      logic [NCH-1:0] ev;
      logic [NCH-1:0] clr;
      cur = mSampled();
      ev  = mEvents(cur);
      clr = (busWrEn && busAddr == 3'd4) ? busWrData[NCH-1:0] : '0;
      mSt = (mSt & ~clr) | ev;
      if (busWrEn) begin
        case (busAddr)
          3'd0: mDelay = busWrData & 32'h0000_FFFF;
          3'd1: mKind  = busWrData & 32'h00FF_FFFF;
          3'd2: mEn    = busWrData[NCH-1:0];
          3'd6: mEn    = mEn | busWrData[NCH-1:0];
          3'd7: mEn    = mEn & ~busWrData[NCH-1:0];
          default: ;
        endcase
      end
      mPrev = cur;
      hist.push_front(rawIn);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, mid high phase
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      check("R9 irq", DW'(irq), DW'(|(mSt & mEn)));
      check(tagFor(busAddr), busRdData, mRead(busAddr));
    end
  end

  task automatic busWrite(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic probe(logic [2:0] a, string tag);
    @(negedge clk);
    busAddr = a;
    @(posedge clk);
    #1;
    check(tag, busRdData, mRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      busAddr = 3'(a);
      #0.5;
      check("R1 reset read", busRdData, '0);
    end
    check("R1 reset irq", DW'(irq), '0);
    @(negedge clk);
    rstN = 1'b1;
    probe(3'd3, "R1 status after reset");

    // ch0..3 delays 0..3; kinds: rise, fall, any, low, high, 6, 7, none
    busWrite(3'd0, 32'h0000_00E4);
    busWrite(3'd1, (1) | (2 << 3) | (3 << 6) | (4 << 9) | (5 << 12) | (6 << 15) | (7 << 18));
    probe(3'd0, "R2 delay readback");
    probe(3'd1, "R3 kind readback");

    // walk patterns on the inputs, watching the delayed word (R2)
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rawIn = 8'(8'hA5 ^ (i * 8'h37));
      busAddr = 3'd5;
      idle(2);
    end
    probe(3'd3, "R3 edges latched");

    // R4: level kind re-sets after clear while the level persists
    @(negedge clk); rawIn[3] = 1'b0; rawIn[4] = 1'b1;
    idle(6);
    busWrite(3'd4, 32'hFF);
    probe(3'd3, "R4 status after clear");
    @(negedge clk); busAddr = 3'd3; #2.5;
    check("R4 low level held", DW'(busRdData[3]), 32'd1);
    check("R4 high level held", DW'(busRdData[4]), 32'd1);

    // R5: kinds 6, 7 and 0 never set status
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rawIn[7:5] = rawIn[7:5] ^ 3'b111;
    end
    idle(3);
    busWrite(3'd4, 32'hE0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rawIn[7:5] = rawIn[7:5] ^ 3'b101;
    end
    idle(3);
    @(negedge clk); busAddr = 3'd3; #2.5;
    check("R5 no status for kinds 0,6,7", DW'(busRdData[7:5]), 32'd0);

    // R7: steady inputs, partial clear
    @(negedge clk); rawIn = 8'b0001_1000;   // ch3 high (no low hit), ch4 high
    idle(6);
    busWrite(3'd1, (1) | (2 << 3) | (3 << 6) | (4 << 9));  // ch4 kind none now
    idle(2);
    @(negedge clk); rawIn[0] = 1'b1;
    idle(2);
    @(negedge clk); rawIn[1] = 1'b1;
    idle(3);
    @(negedge clk); rawIn[1] = 1'b0;
    idle(4);
    probe(3'd3, "R7 before clear");
    busWrite(3'd4, 32'h01);
    probe(3'd3, "R7 partial clear");
    @(negedge clk); busAddr = 3'd4; #2.5;
    check("R7 clear address reads 0", busRdData, '0);

    // R8: clear and rising event on ch0 in the same cycle
    @(negedge clk); rawIn[0] = 1'b0;
    idle(2);
    busWrite(3'd4, 32'h01);
    idle(1);
    @(negedge clk); rawIn[0] = 1'b1;      // captured at next edge, event in the cycle after
    busWrite(3'd4, 32'h01);              // write lands in the event cycle
    @(negedge clk); busAddr = 3'd3; #2.5;
    check("R8 event beats clear", DW'(busRdData[0]), 32'd1);

    // R6 / R9 / R10: enable handling
    busWrite(3'd2, 32'h00);
    probe(3'd3, "R6 status latched while disabled");
    check("R9 irq low when disabled", DW'(irq), 32'd0);
    busWrite(3'd6, 32'h05);
    busWrite(3'd7, 32'h01);
    probe(3'd2, "R10 set then clear");
    @(negedge clk); busAddr = 3'd2; #2.5;
    check("R10 enable value", busRdData, 32'h04);
    busWrite(3'd6, 32'h01);
    @(negedge clk); #2.5;
    check("R9 irq high with enabled status", DW'(irq), 32'd1);

    // R11: writes to read-only addresses ignored
    busWrite(3'd3, 32'hFF);
    probe(3'd3, "R11 status unchanged");
    busWrite(3'd5, 32'hFF);
    probe(3'd5, "R11 input unchanged");
    probe(3'd6, "R11 set address reads 0");
    probe(3'd7, "R11 clr address reads 0");

    // pseudo-random stretch, compared every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rawIn = 8'($urandom);
      busAddr = 3'($urandom);
      if (($urandom % 5) == 0) begin
        busWrData = $urandom;
        busWrEn = 1'b1;
      end else begin
        busWrEn = 1'b0;
      end
    end
    @(negedge clk);
    busWrEn = 1'b0;
    idle(4);
    finishRun();
  end

endmodule